// File: doc/BRIEF.md
# Debug run controller

This block sits between a free-running control clock and a slow user design domain and owns that domain's clock enable. A host reaches it through a small register port. With it the host can let the user logic run freely, stop it, advance it one cycle at a time, or run it for a programmed number of cycles. The user domain ticks at a fixed fraction of the control clock: one enable pulse every `PACE_DIV` control cycles. A 64-bit counter records how many user cycles have really executed.

While the user logic runs, the controller watches for stop conditions. These are a user cycle count reaching a programmed value, a masked pattern match on a watch bus, and any enabled assertion input firing. Each of these halts the domain before its next user cycle and raises a sticky interrupt. When a capture buffer signals that it is close to full, the controller freezes the user domain until the pressure goes away. It then resumes in the mode it had before, with any burst count still intact.

Top module: `dbg_run_ctrl`

## Requirements
- R1: After reset the controller is halted (status bits [1:0] = 0), the halt cause (status bits [6:4]) is 0, the interrupt is low, the cycle counter is 0 and `user_ce` stays low.
- R2: A write to address 0 with bit 0 set starts free running (state 1). `user_ce` then pulses once every `PACE_DIV` control cycles, and `cycle_count` rises by one on exactly those cycles.
- R3: A write to address 0 with bit 2 set, while halted, gives exactly one `user_ce` pulse (state 2 while pending). The controller then halts with cause 2.
- R4: A write to address 0 with bit 3 set, while halted, gives exactly as many `user_ce` pulses as the length held at address 1, then halts with cause 3. A length of 0 leaves the controller halted with its cause unchanged.
- R5: With bit 0 of address 6 set, the controller halts with cause 4 when `cycle_count` equals the 64-bit value at addresses 2 (low) and 3 (high). No further user cycle runs.
- R6: With bit 1 of address 6 set, the controller halts with cause 5 when `watch_bus` agrees with the pattern at address 4 in every bit set in the mask at address 5.
- R7: With bit 2 of address 6 set, any `assert_fire` bit halts the controller with cause 6 and raises `irq`. With bit 2 clear, assertion inputs have no effect.
- R8: When several stop conditions hold in one cycle, the cause is 6 for an assertion, otherwise 5 for a pattern match, otherwise 4 for a count match.
- R9: `user_ce` is never high while any `buf_press` bit is high. A running or stepping controller shows state 3 while stalled, then returns to its prior mode with its remaining burst length.
- R10: `irq` (also status bit 8) is raised by causes 4, 5 and 6. It stays high until a write to address 0 with bit 4 set.
- R11: After a run, step or burst command, count and pattern stops are ignored until the first user cycle has executed, so a resume from a stop point always makes progress.
- R12: A write to address 0 with bit 1 set halts a non-halted controller with cause 1, and suppresses `user_ce` in that cycle. Run, step and burst commands are ignored unless the controller is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 3 | Host write address |
| host_wr_data | input | 32 | Host write data |
| host_rd_addr | input | 3 | Host read address (0 = status) |
| host_rd_data | output | 32 | Host read data, combinational |
| watch_bus | input | WATCH_W | Watched user state |
| assert_fire | input | N_ASSERT | Assertion fire inputs |
| buf_press | input | N_CAP | Capture storage near-full flags |
| user_ce | output | 1 | Clock enable for the user domain |
| irq | output | 1 | Sticky breakpoint interrupt |
| cycle_count | output | 64 | Executed user cycles |

## Verification
Three stop conditions can coincide in one control cycle: a count match, a pattern match and an assertion. The bench first arms the count and pattern stops so that both become true after the same resume, and expects cause 5. It then repeats the setup and pulses an assertion input in exactly the cycle following the first user cycle, where both matches are already true, and expects cause 6. A behavioural model run in step with the design judges the stall-versus-completion overlap on every clock: a near-full flag is raised during a burst, and the burst count must survive the freeze.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [1:0] {
    RS_HALTED   = 2'd0,
    RS_RUNNING  = 2'd1,
    RS_STEPPING = 2'd2,
    RS_STALLED  = 2'd3
  } run_state_t;

  typedef enum logic [2:0] {
    HC_NONE   = 3'd0,
    HC_HOST   = 3'd1,
    HC_STEP   = 3'd2,
    HC_BURST  = 3'd3,
    HC_COUNT  = 3'd4,
    HC_MATCH  = 3'd5,
    HC_ASSERT = 3'd6
  } halt_cause_t;

  // register addresses
  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_LEN  = 3'd1;
  localparam logic [2:0] A_BPLO = 3'd2;
  localparam logic [2:0] A_BPHI = 3'd3;
  localparam logic [2:0] A_PAT  = 3'd4;
  localparam logic [2:0] A_MASK = 3'd5;
  localparam logic [2:0] A_EN   = 3'd6;
  localparam logic [2:0] A_CNT  = 3'd7;

  // command bits
  localparam int CB_RUN   = 0;
  localparam int CB_HALT  = 1;
  localparam int CB_STEP  = 2;
  localparam int CB_BURST = 3;
  localparam int CB_CLR   = 4;

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dbg_pace.sv
module dbg_pace #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == PW'(DIV - 1));

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dbg_cycle_ctr.sv
module dbg_cycle_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (en) count_d = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/dbg_halt_detect.sv
module dbg_halt_detect
  import dbg_pkg::*;
#(
  parameter int WATCH_W  = 16,
  parameter int N_ASSERT = 4,
  parameter int CNT_W    = 64
) (
  input  logic                armed,
  input  logic                skip,
  input  logic                en_count,
  input  logic                en_match,
  input  logic                en_assert,
  input  logic [CNT_W-1:0]    count,
  input  logic [CNT_W-1:0]    bp_count,
  input  logic [WATCH_W-1:0]  watch,
  input  logic [WATCH_W-1:0]  pattern,
  input  logic [WATCH_W-1:0]  mask,
  input  logic [N_ASSERT-1:0] assert_fire,
  output logic                hit,
  output halt_cause_t         cause
);
  logic [WATCH_W-1:0] diff;
  logic hit_assert, hit_match, hit_count;

  for (genvar i = 0; i < WATCH_W; i++) begin : g_cmp
    assign diff[i] = mask[i] & (watch[i] ^ pattern[i]);
  end

  assign hit_assert = armed && en_assert && (|assert_fire);
  assign hit_match  = armed && !skip && en_match && (diff == '0);
  assign hit_count  = armed && !skip && en_count && (count == bp_count);
  assign hit        = hit_assert || hit_match || hit_count;

  // fixed priority: assertion, then pattern, then count
  always_comb begin
    if (hit_assert)     cause = HC_ASSERT;
    else if (hit_match) cause = HC_MATCH;
    else if (hit_count) cause = HC_COUNT;
    else                cause = HC_NONE;
  end
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl
  import dbg_pkg::*;
#(
  parameter int WATCH_W  = 16,
  parameter int N_ASSERT = 4,
  parameter int N_CAP    = 4,
  parameter int PACE_DIV = 16,
  parameter int BURST_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_en,
  input  logic [2:0]          host_wr_addr,
  input  logic [31:0]         host_wr_data,
  input  logic [2:0]          host_rd_addr,
  output logic [31:0]         host_rd_data,
  input  logic [WATCH_W-1:0]  watch_bus,
  input  logic [N_ASSERT-1:0] assert_fire,
  input  logic [N_CAP-1:0]    buf_press,
  output logic                user_ce,
  output logic                irq,
  output logic [63:0]         cycle_count
);
  localparam int CNT_W = 64;
  localparam int HALF  = CNT_W / 2;

  logic srst_n;
  logic tick;

  // configuration registers
  logic [BURST_W-1:0] burst_len_q;
  logic [CNT_W-1:0]   bp_q;
  logic [WATCH_W-1:0] pat_q, mask_q;
  logic [2:0]         en_q;

  // control state
  run_state_t         state_q, state_d, saved_q, saved_d;
  halt_cause_t        cause_q, cause_d, hit_cause;
  logic [BURST_W-1:0] rem_q, rem_d;
  logic               step_q, step_d;
  logic               skip_q, skip_d;
  logic               irq_q, irq_d;

  logic cmd_wr, c_run, c_halt, c_step, c_burst, c_clr;
  logic press_any, armed, hit;

  dbg_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  dbg_pace #(.DIV(PACE_DIV)) u_pace (.clk(clk), .rst_n(srst_n), .tick(tick));

  dbg_cycle_ctr #(.W(CNT_W)) u_cycle_ctr (
    .clk(clk), .rst_n(srst_n), .en(user_ce), .count(cycle_count)
  );

  // command decode, priority halt > step > burst > run
  assign cmd_wr  = host_wr_en && (host_wr_addr == A_CMD);
  assign c_halt  = cmd_wr && host_wr_data[CB_HALT];
  assign c_step  = cmd_wr && host_wr_data[CB_STEP] && !c_halt;
  assign c_burst = cmd_wr && host_wr_data[CB_BURST] && !c_halt && !host_wr_data[CB_STEP];
  assign c_run   = cmd_wr && host_wr_data[CB_RUN] && !c_halt && !host_wr_data[CB_STEP]
                   && !host_wr_data[CB_BURST];
  assign c_clr   = cmd_wr && host_wr_data[CB_CLR];

  assign press_any = |buf_press;
  assign armed     = (state_q != RS_HALTED);

  dbg_halt_detect #(
    .WATCH_W(WATCH_W), .N_ASSERT(N_ASSERT), .CNT_W(CNT_W)
  ) u_halt_detect (
    .armed(armed), .skip(skip_q),
    .en_count(en_q[0]), .en_match(en_q[1]), .en_assert(en_q[2]),
    .count(cycle_count), .bp_count(bp_q),
    .watch(watch_bus), .pattern(pat_q), .mask(mask_q),
    .assert_fire(assert_fire),
    .hit(hit), .cause(hit_cause)
  );

  // user clock enable: paced, active mode, no pressure, no stop pending
  assign user_ce = tick && ((state_q == RS_RUNNING) || (state_q == RS_STEPPING))
                   && !press_any && !hit && !c_halt;

  // configuration registers with explicit write enables
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      burst_len_q <= '0;
      bp_q        <= '0;
      pat_q       <= '0;
      mask_q      <= '0;
      en_q        <= '0;
    end else if (host_wr_en) begin
      if (host_wr_addr == A_LEN)  burst_len_q <= host_wr_data[BURST_W-1:0];
      if (host_wr_addr == A_BPLO) bp_q[HALF-1:0] <= host_wr_data;
      if (host_wr_addr == A_BPHI) bp_q[CNT_W-1:HALF] <= host_wr_data;
      if (host_wr_addr == A_PAT)  pat_q  <= host_wr_data[WATCH_W-1:0];
      if (host_wr_addr == A_MASK) mask_q <= host_wr_data[WATCH_W-1:0];
      if (host_wr_addr == A_EN)   en_q   <= host_wr_data[2:0];
    end
  end

  // next-state logic
  always_comb begin
    state_d = state_q;
    saved_d = saved_q;
    cause_d = cause_q;
    rem_d   = rem_q;
    step_d  = step_q;
    skip_d  = skip_q;
    irq_d   = irq_q;

    if (user_ce) begin
      skip_d = 1'b0;
      if (state_q == RS_STEPPING) begin
        rem_d = rem_q - BURST_W'(1);
        if (rem_q == BURST_W'(1)) begin
          state_d = RS_HALTED;
          cause_d = step_q ? HC_STEP : HC_BURST;
        end
      end
    end

    if (state_q == RS_HALTED) begin
      if (c_step) begin
        state_d = RS_STEPPING;
        rem_d   = BURST_W'(1);
        step_d  = 1'b1;
        skip_d  = 1'b1;
      end else if (c_burst && (burst_len_q != '0)) begin
        state_d = RS_STEPPING;
        rem_d   = burst_len_q;
        step_d  = 1'b0;
        skip_d  = 1'b1;
      end else if (c_run) begin
        state_d = RS_RUNNING;
        skip_d  = 1'b1;
      end
    end else if (hit) begin
      state_d = RS_HALTED;
      cause_d = hit_cause;
    end else if (c_halt) begin
      state_d = RS_HALTED;
      cause_d = HC_HOST;
    end else if (state_q == RS_STALLED) begin
      if (!press_any) state_d = saved_q;
    end else if (press_any) begin
      saved_d = state_q;
      state_d = RS_STALLED;
    end

    if (c_clr) irq_d = 1'b0;
    if (hit)   irq_d = 1'b1;
  end

  // state registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= RS_HALTED;
      saved_q <= RS_RUNNING;
      cause_q <= HC_NONE;
      rem_q   <= '0;
      step_q  <= 1'b0;
      skip_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      saved_q <= saved_d;
      cause_q <= cause_d;
      rem_q   <= rem_d;
      step_q  <= step_d;
      skip_q  <= skip_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;

  // read mux
  always_comb begin
    host_rd_data = '0;
    case (host_rd_addr)
      A_CMD:  host_rd_data = {23'd0, irq_q, 1'b0, cause_q, 2'b00, state_q};
      A_LEN:  host_rd_data[BURST_W-1:0] = burst_len_q;
      A_BPLO: host_rd_data = bp_q[HALF-1:0];
      A_BPHI: host_rd_data = bp_q[CNT_W-1:HALF];
      A_PAT:  host_rd_data[WATCH_W-1:0] = pat_q;
      A_MASK: host_rd_data[WATCH_W-1:0] = mask_q;
      A_EN:   host_rd_data[2:0] = en_q;
      A_CNT:  host_rd_data = cycle_count[HALF-1:0];
      default: host_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dbg_run_ctrl_chk.sv
module dbg_run_ctrl_chk
  import dbg_pkg::*;
#(
  parameter int N_ASSERT = 4,
  parameter int N_CAP    = 4
) (
  input logic                clk,
  input logic                srst_n,
  input logic                user_ce,
  input logic [N_CAP-1:0]    buf_press,
  input logic [63:0]         cycle_count,
  input run_state_t          state,
  input logic                irq,
  input logic                irq_clr,
  input logic [N_ASSERT-1:0] assert_fire,
  input logic                assert_en
);
  // R9
  no_ce_under_press_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (|buf_press) |-> !user_ce);

  // R9
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state == RS_STALLED) |-> !user_ce);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!srst_n)
    user_ce |=> (cycle_count == $past(cycle_count) + 64'd1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !user_ce |=> (cycle_count == $past(cycle_count)));

  // R1
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (state == RS_HALTED) |-> !user_ce);

  // R7
  assert_stop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((state != RS_HALTED) && assert_en && (|assert_fire)) |=> ((state == RS_HALTED) && irq));

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind dbg_run_ctrl dbg_run_ctrl_chk #(.N_ASSERT(N_ASSERT), .N_CAP(N_CAP)) u_run_chk (
  .clk(clk), .srst_n(srst_n), .user_ce(user_ce), .buf_press(buf_press),
  .cycle_count(cycle_count), .state(state_q), .irq(irq), .irq_clr(c_clr),
  .assert_fire(assert_fire), .assert_en(en_q[2])
);

// File: tb/test_dbg_run_ctrl.sv
`timescale 1ns/1ps
module test_dbg_run_ctrl;
  localparam int WW  = 16;
  localparam int NA  = 4;
  localparam int NC  = 4;
  localparam int DIV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          host_wr_en = 1'b0;
  logic [2:0]    host_wr_addr = '0;
  logic [31:0]   host_wr_data = '0;
  logic [2:0]    host_rd_addr = '0;
  logic [31:0]   host_rd_data;
  logic [WW-1:0] watch_bus;
  logic [NA-1:0] assert_fire = '0;
  logic [NC-1:0] buf_press = '0;
  logic          user_ce, irq;
  logic [63:0]   cycle_count;

  dbg_run_ctrl #(.WATCH_W(WW), .N_ASSERT(NA), .N_CAP(NC), .PACE_DIV(DIV)) i_dbg_run_ctrl (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .watch_bus(watch_bus), .assert_fire(assert_fire), .buf_press(buf_press),
    .user_ce(user_ce), .irq(irq), .cycle_count(cycle_count)
  );

  // stand-in user design: a counter advanced on each enabled user cycle
  logic [WW-1:0] usr_state;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) usr_state <= '0;
    else if (user_ce) usr_state <= usr_state + 1'b1;
  assign watch_bus = usr_state;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [1:0]    m_rs = 2'b00;
  int            m_pace = 0;
  int            m_state = 0, m_saved = 1, m_cause = 0;
  logic          m_irq = 1'b0, m_skip = 1'b0, m_isstep = 1'b0;
  longint unsigned m_cnt = 0, m_bp = 0;
  int unsigned   m_rem = 0, m_len = 0;
  logic [WW-1:0] m_pat = '0, m_mask = '0;
  logic [2:0]    m_en = '0;

  logic e_ce = 1'b0, e_hit = 1'b0;
  int   e_cz = 0;
  logic e_halt = 1'b0, e_step = 1'b0, e_burst = 1'b0, e_run = 1'b0, e_clr = 1'b0;

  // expected combinational values, then compare everything
  always @(negedge clk) begin
    logic cw, ah, sh, ch, act;
    #1;
    cw      = host_wr_en && (host_wr_addr == 3'd0);
    e_halt  = cw && host_wr_data[1];
    e_step  = cw && host_wr_data[2] && !e_halt;
    e_burst = cw && host_wr_data[3] && !e_halt && !host_wr_data[2];
    e_run   = cw && host_wr_data[0] && !e_halt && !host_wr_data[2] && !host_wr_data[3];
    e_clr   = cw && host_wr_data[4];
    act = (m_state != 0);
    ah  = act && m_en[2] && (assert_fire != '0);
    sh  = act && !m_skip && m_en[1] && (((watch_bus ^ m_pat) & m_mask) == '0);
    ch  = act && !m_skip && m_en[0] && (m_cnt == m_bp);
    e_hit = ah || sh || ch;
    e_cz  = ah ? 6 : (sh ? 5 : (ch ? 4 : 0));
    e_ce  = (m_pace == DIV - 1) && (m_state == 1 || m_state == 2) && (buf_press == '0)
            && !e_hit && !e_halt;
    chk({cur_req, " user_ce"}, 64'(user_ce), 64'(e_ce));
    chk({cur_req, " status"}, 64'(host_rd_data[8:0]),
        64'({m_irq, 1'b0, 3'(m_cause), 2'b00, 2'(m_state)}));
    chk({cur_req, " cycle_count"}, cycle_count, m_cnt);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs <= 2'b00;
    end else begin
      m_rs <= {m_rs[0], 1'b1};
    end
    if (!rst_n || !m_rs[1]) begin
      m_pace <= 0; m_state <= 0; m_saved <= 1; m_cause <= 0; m_irq <= 1'b0;
      m_skip <= 1'b0; m_isstep <= 1'b0; m_cnt <= 0; m_bp <= 0; m_rem <= 0;
      m_len <= 0; m_pat <= '0; m_mask <= '0; m_en <= '0;
    end else begin
      m_pace <= (m_pace == DIV - 1) ? 0 : m_pace + 1;
      if (host_wr_en) begin
        case (host_wr_addr)
          3'd1: m_len <= host_wr_data;
          3'd2: m_bp[31:0] <= host_wr_data;
          3'd3: m_bp[63:32] <= host_wr_data;
          3'd4: m_pat <= host_wr_data[WW-1:0];
          3'd5: m_mask <= host_wr_data[WW-1:0];
          3'd6: m_en <= host_wr_data[2:0];
          default: ;
        endcase
      end
      if (e_ce) begin
        m_cnt <= m_cnt + 1;
        m_skip <= 1'b0;
        if (m_state == 2) begin
          m_rem <= m_rem - 1;
          if (m_rem == 1) begin
            m_state <= 0;
            m_cause <= m_isstep ? 2 : 3;
          end
        end
      end
      if (m_state == 0) begin
        if (e_step) begin
          m_state <= 2; m_rem <= 1; m_isstep <= 1'b1; m_skip <= 1'b1;
        end else if (e_burst && m_len != 0) begin
          m_state <= 2; m_rem <= m_len; m_isstep <= 1'b0; m_skip <= 1'b1;
        end else if (e_run) begin
          m_state <= 1; m_skip <= 1'b1;
        end
      end else if (e_hit) begin
        m_state <= 0; m_cause <= e_cz;
      end else if (e_halt) begin
        m_state <= 0; m_cause <= 1;
      end else if (m_state == 3) begin
        if (buf_press == '0) m_state <= m_saved;
      end else if (buf_press != '0) begin
        m_saved <= m_state; m_state <= 3;
      end
      if (e_hit) m_irq <= 1'b1;
      else if (e_clr) m_irq <= 1'b0;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hw(input logic [2:0] a, input logic [31:0] d);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0; host_wr_data = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ce();
    for (int k = 0; k < 200; k++) begin
      #1;
      if (user_ce) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  function automatic logic [1:0] st();
    return host_rd_data[1:0];
  endfunction
  function automatic logic [2:0] cz();
    return host_rd_data[6:4];
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    longint unsigned c, c0;
    logic [WW-1:0] s;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);

    cur_req = "R1";
    chk("R1 state", 64'(st()), 0);
    chk("R1 cause", 64'(cz()), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 count", cycle_count, 0);

    cur_req = "R3";
    hw(3'd0, 32'h4);
    wait_n(40);
    chk("R3 state", 64'(st()), 0);
    chk("R3 cause", 64'(cz()), 2);
    chk("R3 count", cycle_count, 1);

    cur_req = "R4";
    hw(3'd1, 32'd5);
    hw(3'd0, 32'h8);
    wait_n(100);
    chk("R4 cause", 64'(cz()), 3);
    chk("R4 count", cycle_count, 6);
    hw(3'd1, 32'd0);
    hw(3'd0, 32'h8);
    chk("R4 zero len state", 64'(st()), 0);
    wait_n(40);
    chk("R4 zero len count", cycle_count, 6);
    chk("R4 zero len cause", 64'(cz()), 3);

    cur_req = "R2";
    hw(3'd0, 32'h1);
    wait_n(70);
    chk("R2 running", 64'(st()), 1);
    chk("R2 advanced", 64'(cycle_count > 64'd9), 1);
    cur_req = "R12";
    hw(3'd0, 32'h4);
    chk("R12 step ignored", 64'(st()), 1);
    hw(3'd0, 32'h2);
    chk("R12 host halt", 64'(st()), 0);
    chk("R12 host cause", 64'(cz()), 1);

    cur_req = "R5";
    c = cycle_count + 3;
    hw(3'd2, c[31:0]);
    hw(3'd3, c[63:32]);
    hw(3'd6, 32'h1);
    hw(3'd0, 32'h1);
    wait_n(100);
    chk("R5 state", 64'(st()), 0);
    chk("R5 cause", 64'(cz()), 4);
    chk("R5 count", cycle_count, c);
    cur_req = "R10";
    wait_n(20);
    chk("R10 irq held", 64'(irq), 1);
    hw(3'd0, 32'h10);
    chk("R10 irq cleared", 64'(irq), 0);

    cur_req = "R11";
    hw(3'd0, 32'h1);
    wait_n(40);
    chk("R11 resumed", 64'(st()), 1);
    chk("R11 progress", 64'(cycle_count > c), 1);
    hw(3'd0, 32'h2);

    cur_req = "R6";
    hw(3'd6, 32'h2);
    hw(3'd5, 32'h000F);
    hw(3'd4, 32'h0005);
    hw(3'd0, 32'h1);
    wait_n(320);
    chk("R6 state", 64'(st()), 0);
    chk("R6 cause", 64'(cz()), 5);
    chk("R6 watch", 64'(watch_bus[3:0]), 5);
    hw(3'd0, 32'h10);

    cur_req = "R8";
    s = watch_bus + 1'b1;
    c = cycle_count + 1;
    hw(3'd4, 32'(s));
    hw(3'd2, c[31:0]);
    hw(3'd3, c[63:32]);
    hw(3'd6, 32'h3);
    hw(3'd0, 32'h1);
    wait_n(40);
    chk("R8 match over count", 64'(cz()), 5);
    chk("R8 count", cycle_count, c);
    hw(3'd0, 32'h10);
    s = watch_bus + 1'b1;
    c = cycle_count + 1;
    hw(3'd4, 32'(s));
    hw(3'd2, c[31:0]);
    hw(3'd3, c[63:32]);
    hw(3'd6, 32'h7);
    hw(3'd0, 32'h1);
    wait_ce();
    assert_fire = 4'b0100;
    @(negedge clk);
    assert_fire = '0;
    chk("R8 assert over all", 64'(cz()), 6);
    chk("R8 irq", 64'(irq), 1);
    hw(3'd0, 32'h10);

    cur_req = "R7";
    hw(3'd6, 32'h4);
    hw(3'd0, 32'h1);
    wait_n(30);
    assert_fire = 4'b0001;
    @(negedge clk);
    assert_fire = '0;
    chk("R7 state", 64'(st()), 0);
    chk("R7 cause", 64'(cz()), 6);
    chk("R7 irq", 64'(irq), 1);
    hw(3'd0, 32'h10);
    hw(3'd6, 32'h0);
    hw(3'd0, 32'h1);
    wait_n(5);
    assert_fire = 4'b1000;
    @(negedge clk);
    assert_fire = '0;
    chk("R7 disabled no stop", 64'(st()), 1);
    chk("R7 disabled no irq", 64'(irq), 0);
    hw(3'd0, 32'h2);

    cur_req = "R9";
    c0 = cycle_count;
    hw(3'd1, 32'd4);
    hw(3'd0, 32'h8);
    wait_ce();
    buf_press = 4'b0010;
    wait_n(2);
    chk("R9 stalled", 64'(st()), 3);
    c = cycle_count;
    wait_n(60);
    chk("R9 frozen", cycle_count, c);
    chk("R9 still stalled", 64'(st()), 3);
    buf_press = '0;
    wait_n(100);
    chk("R9 burst done", 64'(cz()), 3);
    chk("R9 burst total", cycle_count, c0 + 4);

    wait_n(4);
    finish_up();
  end
endmodule